// File: doc/BRIEF.md
# Addressing-Mode Operand Fetcher

This block sits beside the decoder of an 8-bit processor core with a 16-bit address space. For each instruction it works out the effective address and fetches the operand byte. The caller presents an addressing-mode code, the address of the first byte after the opcode, the two index registers and the accumulator. The block then walks a short sequence of single-byte reads on an asynchronous memory read port. It fetches the instruction's argument bytes, then any pointer bytes, then the operand itself.

When the result is ready the block pulses `done` for one cycle. The effective address, operand, argument byte count and a page-cross flag stay on the outputs until the next request is accepted. The page-cross flag feeds cycle accounting in the surrounding core. Every zero-page and pointer calculation wraps inside page zero. The indirect-jump pointer fetch never carries into the next page.

Top module: `addr_mode_gen`

## Requirements
- R1: `reqReady` is high only when idle, and a request is taken when `reqValid` and `reqReady` are both high. `done` is high for exactly one cycle per request. The result outputs hold their values after `done` until another request is accepted. After reset `reqReady`=1, `done`=0, `memRd`=0 and `effAddr`=0.
- R2: `byteCount` gives the argument bytes read after the opcode: 0 for modes 0 and 1, 2 for modes 7, 8, 9 and 10, and 1 for modes 2–6, 11 and 12. The mode codes are: 0 accumulator, 1 implied, 2 immediate, 3 relative, 4 zero page, 5 zero page+X, 6 zero page+Y, 7 absolute, 8 absolute+X, 9 absolute+Y, 10 indirect jump, 11 pre-indexed pointer (zp+X), 12 post-indexed pointer (zp then +Y).
- R3: In absolute mode the address low byte is read at `pc` and the high byte at `pc+1`.
- R4: In modes 8 and 9, X or Y is added to the 16-bit little-endian base. `pageCross` is 1 exactly when the high byte of the sum differs from that of the base.
- R5: Modes 4, 5 and 6 give an address in page zero. The index sum keeps only its low 8 bits.
- R6: In mode 11 the pointer low byte is read at (arg+X) mod 256 and the high byte at (arg+X+1) mod 256. Both reads are in page zero, and the pointer is the effective address.
- R7: In mode 12 the pointer is read at arg and (arg+1) mod 256 in page zero. Y is added to the 16-bit pointer, and `pageCross` is set when the high byte changes.
- R8: In mode 10 the pointer low byte is read at {hi,lo} and the high byte at {hi,(lo+1) mod 256}. The pointer is the effective address, the operand is 0, and no operand read follows (4 reads in total).
- R9: Mode 0 returns the accumulator as operand and mode 1 returns 0. Both give effective address 0 and perform no memory read.
- R10: Mode 2 returns the byte at `pc` as operand, with effective address `pc`. Mode 3 returns the offset byte as operand, with effective address pc+1+sign-extended offset. In mode 3, `pageCross` is set when that target's high byte differs from that of pc+1.
- R11: In modes 4–9, 11 and 12 the operand is the byte read at the effective address.
- R12: `pageCross` is 0 for every mode other than 3, 8, 9 and 12.
- R13: Changes on `mode`, `pc`, `xIdx`, `yIdx`, `accIn` and `reqValid` while a request is in progress do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Block is idle and will take a request |
| mode | input | 4 | Addressing-mode code (see R2) |
| pc | input | 16 | Address of the first byte after the opcode |
| xIdx | input | 8 | X index register |
| yIdx | input | 8 | Y index register |
| accIn | input | 8 | Accumulator value |
| memRd | output | 1 | Read strobe for the memory port |
| memAddr | output | 16 | Read address |
| memData | input | 8 | Read data, valid in the same cycle as `memAddr` |
| done | output | 1 | One-cycle result-valid pulse |
| effAddr | output | 16 | Effective address |
| operand | output | 8 | Operand byte |
| byteCount | output | 2 | Argument bytes consumed |
| pageCross | output | 1 | Page-boundary crossing flag |

## Verification
The hardest cases to reach are the pointer wraps. An indirect-jump pointer whose low byte is 0xFF must have its high byte fetched from the start of the same page. A pre-indexed pointer must sit at zero-page address 0xFF so that its second byte comes from 0x00. Both depend on the bytes in memory, not on port values. The bench therefore models memory as a salted function of the address and solves for the salt (or for X) so that the argument byte lands on the wrapping value. Random requests with random salts cover page crossings for the indexed and relative modes. Some of them also scramble the inputs during the request to exercise R13.

// File: rtl/amg_pkg.sv
package amg_pkg;

  typedef enum logic [3:0] {
    AM_ACC = 4'd0,  AM_IMP = 4'd1,  AM_IMM = 4'd2,  AM_REL = 4'd3,
    AM_ZPG = 4'd4,  AM_ZPX = 4'd5,  AM_ZPY = 4'd6,  AM_ABS = 4'd7,
    AM_ABX = 4'd8,  AM_ABY = 4'd9,  AM_IND = 4'd10, AM_IZX = 4'd11,
    AM_IZY = 4'd12
  } amMode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OP0, S_OP1, S_PTR0, S_PTR1, S_EA, S_DATA, S_DONE
  } seqState_e;

  typedef enum logic [2:0] {
    SEL_PC, SEL_PC1, SEL_PTRLO, SEL_PTRHI, SEL_EA
  } addrSel_e;

  typedef struct packed {
    logic     latchReq;
    logic     capOp0;
    logic     capOp1;
    logic     capPtr0;
    logic     capPtr1;
    logic     formEa;
    logic     capData;
    addrSel_e addrSel;
  } ctlStrobes_t;

endpackage

// File: rtl/amg_ctrl.sv
module amg_ctrl
  import amg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [3:0]  mode,
  output logic        reqReady,
  output logic        memRd,
  output logic        done,
  output logic [1:0]  byteCount,
  output amMode_e     modeQ,
  output ctlStrobes_t ctl
);

  seqState_e state, stateNext;
  amMode_e   modeIn;

  assign modeIn = amMode_e'(mode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      modeQ <= AM_IMP;
    end else begin
      state <= stateNext;
      if (ctl.latchReq) modeQ <= modeIn;
    end
  end

  always_comb begin
    stateNext = state;
    ctl = '0;
    ctl.addrSel = SEL_PC;
    memRd = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          if (modeIn inside {AM_IMM, AM_REL, AM_ZPG, AM_ZPX, AM_ZPY, AM_ABS,
                             AM_ABX, AM_ABY, AM_IND, AM_IZX, AM_IZY})
            stateNext = S_OP0;
          else
            stateNext = S_EA;
        end
      end
      S_OP0: begin
        memRd = 1'b1;
        ctl.capOp0 = 1'b1;
        ctl.addrSel = SEL_PC;
        if (modeQ inside {AM_ABS, AM_ABX, AM_ABY, AM_IND}) stateNext = S_OP1;
        else if (modeQ inside {AM_IZX, AM_IZY})            stateNext = S_PTR0;
        else                                               stateNext = S_EA;
      end
      S_OP1: begin
        memRd = 1'b1;
        ctl.capOp1 = 1'b1;
        ctl.addrSel = SEL_PC1;
        stateNext = (modeQ == AM_IND) ? S_PTR0 : S_EA;
      end
      S_PTR0: begin
        memRd = 1'b1;
        ctl.capPtr0 = 1'b1;
        ctl.addrSel = SEL_PTRLO;
        stateNext = S_PTR1;
      end
      S_PTR1: begin
        memRd = 1'b1;
        ctl.capPtr1 = 1'b1;
        ctl.addrSel = SEL_PTRHI;
        stateNext = S_EA;
      end
      S_EA: begin
        ctl.formEa = 1'b1;
        if (modeQ inside {AM_ZPG, AM_ZPX, AM_ZPY, AM_ABS, AM_ABX, AM_ABY,
                          AM_IZX, AM_IZY})
          stateNext = S_DATA;
        else
          stateNext = S_DONE;
      end
      S_DATA: begin
        memRd = 1'b1;
        ctl.capData = 1'b1;
        ctl.addrSel = SEL_EA;
        stateNext = S_DONE;
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_DONE);

  always_comb begin
    case (modeQ)
      AM_ABS, AM_ABX, AM_ABY, AM_IND:                        byteCount = 2'd2;
      AM_IMM, AM_REL, AM_ZPG, AM_ZPX, AM_ZPY, AM_IZX, AM_IZY: byteCount = 2'd1;
      default:                                               byteCount = 2'd0;
    endcase
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memRd);

  // R9
  no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchReq && modeIn inside {AM_ACC, AM_IMP}) |=> !memRd);

endmodule

// File: rtl/amg_dpath.sv
module amg_dpath
  import amg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           ctl,
  input  amMode_e               modeQ,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic [DATA_W-1:0]     xIn,
  input  logic [DATA_W-1:0]     yIn,
  input  logic [DATA_W-1:0]     accIn,
  input  logic [DATA_W-1:0]     memData,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0]   effAddr,
  output logic [DATA_W-1:0]     operand,
  output logic                  pageCross
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] PAGE_ZERO = '0;

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] xQ, yQ, accQ;
  logic [DATA_W-1:0] opLo, opHi, ptrLo, ptrHi;

  logic [ADDR_W-1:0] pcNext1, base16, ptr16, relTarget;
  logic [ADDR_W-1:0] ptrLoAddr, ptrHiAddr, eaNext;
  logic [DATA_W-1:0] zpSum, izxLo, opNext;
  logic              crossNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0; xQ <= '0; yQ <= '0; accQ <= '0;
      opLo <= '0; opHi <= '0; ptrLo <= '0; ptrHi <= '0;
      effAddr <= '0; operand <= '0; pageCross <= 1'b0;
    end else begin
      if (ctl.latchReq) begin
        pcQ  <= pcIn;
        xQ   <= xIn;
        yQ   <= yIn;
        accQ <= accIn;
      end
      if (ctl.capOp0)  opLo  <= memData;
      if (ctl.capOp1)  opHi  <= memData;
      if (ctl.capPtr0) ptrLo <= memData;
      if (ctl.capPtr1) ptrHi <= memData;
      if (ctl.formEa) begin
        effAddr   <= eaNext;
        pageCross <= crossNext;
        operand   <= opNext;
      end
      if (ctl.capData) operand <= memData;
    end
  end

  assign pcNext1   = pcQ + ADDR_W'(1);
  assign base16    = {opHi, opLo};
  assign ptr16     = {ptrHi, ptrLo};
  assign relTarget = pcNext1 + {{DATA_W{opLo[DATA_W-1]}}, opLo};
  assign izxLo     = opLo + xQ;
  assign zpSum     = opLo + ((modeQ == AM_ZPY) ? yQ : xQ);

  // Pointer locations: page-zero wrap for the indexed pointer modes,
  // in-page wrap for the indirect jump.
  always_comb begin
    case (modeQ)
      AM_IZX: begin
        ptrLoAddr = {PAGE_ZERO, izxLo};
        ptrHiAddr = {PAGE_ZERO, izxLo + DATA_W'(1)};
      end
      AM_IZY: begin
        ptrLoAddr = {PAGE_ZERO, opLo};
        ptrHiAddr = {PAGE_ZERO, opLo + DATA_W'(1)};
      end
      default: begin
        ptrLoAddr = {opHi, opLo};
        ptrHiAddr = {opHi, opLo + DATA_W'(1)};
      end
    endcase
  end

  always_comb begin
    eaNext    = '0;
    crossNext = 1'b0;
    opNext    = '0;
    case (modeQ)
      AM_ACC: opNext = accQ;
      AM_IMM: begin eaNext = pcQ; opNext = opLo; end
      AM_REL: begin
        eaNext    = relTarget;
        opNext    = opLo;
        crossNext = relTarget[ADDR_W-1:DATA_W] != pcNext1[ADDR_W-1:DATA_W];
      end
      AM_ZPG: eaNext = {PAGE_ZERO, opLo};
      AM_ZPX, AM_ZPY: eaNext = {PAGE_ZERO, zpSum};
      AM_ABS: eaNext = base16;
      AM_ABX, AM_ABY: begin
        eaNext    = base16 + {PAGE_ZERO, (modeQ == AM_ABY) ? yQ : xQ};
        crossNext = eaNext[ADDR_W-1:DATA_W] != opHi;
      end
      AM_IND, AM_IZX: eaNext = ptr16;
      AM_IZY: begin
        eaNext    = ptr16 + {PAGE_ZERO, yQ};
        crossNext = eaNext[ADDR_W-1:DATA_W] != ptrHi;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (ctl.addrSel)
      SEL_PC:    memAddr = pcQ;
      SEL_PC1:   memAddr = pcNext1;
      SEL_PTRLO: memAddr = ptrLoAddr;
      SEL_PTRHI: memAddr = ptrHiAddr;
      default:   memAddr = effAddr;
    endcase
  end

  // R8
  ind_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrSel == SEL_PTRHI && modeQ == AM_IND)
      |-> memAddr[ADDR_W-1:DATA_W] == $past(memAddr[ADDR_W-1:DATA_W]));

  // R6 R7
  zp_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrSel inside {SEL_PTRLO, SEL_PTRHI} && modeQ inside {AM_IZX, AM_IZY})
      |-> memAddr[ADDR_W-1:DATA_W] == PAGE_ZERO);

  // R5
  zp_ea_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.formEa && modeQ inside {AM_ZPG, AM_ZPX, AM_ZPY})
      |=> effAddr[ADDR_W-1:DATA_W] == PAGE_ZERO);

  // R12
  cross_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.formEa && !(modeQ inside {AM_REL, AM_ABX, AM_ABY, AM_IZY}))
      |=> !pageCross);

  // R11
  data_ea_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capData |-> memAddr == $past(eaNext));

endmodule

// File: rtl/addr_mode_gen.sv
module addr_mode_gen
  import amg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [3:0]          mode,
  input  logic [2*DATA_W-1:0] pc,
  input  logic [DATA_W-1:0]   xIdx,
  input  logic [DATA_W-1:0]   yIdx,
  input  logic [DATA_W-1:0]   accIn,
  output logic                memRd,
  output logic [2*DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0]   memData,
  output logic                done,
  output logic [2*DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0]   operand,
  output logic [1:0]          byteCount,
  output logic                pageCross
);

  ctlStrobes_t ctl;
  amMode_e     modeQ;

  amg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .reqReady(reqReady), .memRd(memRd), .done(done),
    .byteCount(byteCount), .modeQ(modeQ), .ctl(ctl)
  );

  amg_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modeQ(modeQ),
    .pcIn(pc), .xIn(xIdx), .yIn(yIdx), .accIn(accIn),
    .memData(memData), .memAddr(memAddr), .effAddr(effAddr),
    .operand(operand), .pageCross(pageCross)
  );

endmodule

// File: tb/sim_addr_mode_gen.sv
module sim_addr_mode_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  xIdx = '0, yIdx = '0, accIn = '0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic        done;
  logic [15:0] effAddr;
  logic [7:0]  operand;
  logic [1:0]  byteCount;
  logic        pageCross;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] salt = 8'h00;

  always #2 clk = ~clk;

  addr_mode_gen u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .mode(mode), .pc(pc), .xIdx(xIdx), .yIdx(yIdx), .accIn(accIn),
    .memRd(memRd), .memAddr(memAddr), .memData(memData), .done(done),
    .effAddr(effAddr), .operand(operand), .byteCount(byteCount),
    .pageCross(pageCross)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    logic [7:0] p, q;
    p = a[7:0] * 8'd13;
    q = a[15:8] * 8'd89;
    return p ^ q ^ salt;
  endfunction

  assign memData = memFn(memAddr);

  // Salt that makes memFn(a) equal v.
  function automatic logic [7:0] saltFor(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] p, q;
    p = a[7:0] * 8'd13;
    q = a[15:8] * 8'd89;
    return p ^ q ^ v;
  endfunction

  function automatic string tagFor(input logic [3:0] m);
    case (m)
      4'd0, 4'd1:        return "R9";
      4'd2, 4'd3:        return "R10";
      4'd4, 4'd5, 4'd6:  return "R5";
      4'd7:              return "R3";
      4'd8, 4'd9:        return "R4";
      4'd10:             return "R8";
      4'd11:             return "R6";
      default:           return "R7";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected behaviour from the requirements.
  task automatic model(input logic [3:0] m, input logic [15:0] p,
                       input logic [7:0] xv, input logic [7:0] yv, input logic [7:0] av,
                       output logic [15:0] ea, output logic [7:0] od,
                       output logic cr, output logic [1:0] nb, output int rd);
    logic [7:0]  b0, b1, zl, pl, ph;
    logic [15:0] base, ptr, nxt;
    b0 = memFn(p);
    b1 = memFn(p + 16'd1);
    ea = '0; od = '0; cr = 1'b0; nb = 2'd1; rd = 0;
    case (m)
      4'd0: begin od = av; nb = 2'd0; end
      4'd1: begin nb = 2'd0; end
      4'd2: begin ea = p; od = b0; rd = 1; end
      4'd3: begin
        nxt = p + 16'd1;
        ea = nxt + {{8{b0[7]}}, b0};
        od = b0; rd = 1;
        cr = ea[15:8] != nxt[15:8];
      end
      4'd4, 4'd5, 4'd6: begin
        zl = b0 + ((m == 4'd4) ? 8'd0 : (m == 4'd5) ? xv : yv);
        ea = {8'h00, zl}; od = memFn(ea); rd = 2;
      end
      4'd7, 4'd8, 4'd9: begin
        base = {b1, b0};
        ea = base + {8'h00, (m == 4'd7) ? 8'd0 : (m == 4'd8) ? xv : yv};
        cr = (m != 4'd7) && (ea[15:8] != b1);
        od = memFn(ea); nb = 2'd2; rd = 3;
      end
      4'd10: begin
        zl = b0 + 8'd1;
        pl = memFn({b1, b0});
        ph = memFn({b1, zl});
        ea = {ph, pl}; nb = 2'd2; rd = 4;
      end
      4'd11: begin
        zl = b0 + xv;
        pl = memFn({8'h00, zl});
        zl = zl + 8'd1;
        ph = memFn({8'h00, zl});
        ea = {ph, pl}; od = memFn(ea); rd = 4;
      end
      default: begin
        zl = b0 + 8'd1;
        pl = memFn({8'h00, b0});
        ph = memFn({8'h00, zl});
        ptr = {ph, pl};
        ea = ptr + {8'h00, yv};
        cr = ea[15:8] != ph;
        od = memFn(ea); rd = 4;
      end
    endcase
  endtask

  task automatic runReq(input logic [3:0] m, input logic [15:0] p,
                        input logic [7:0] xv, input logic [7:0] yv, input logic [7:0] av,
                        input logic scramble);
    logic [15:0] ea; logic [7:0] od; logic cr; logic [1:0] nb; int rd;
    int seen; int wait_n; string t; string opt; string sx;
    model(m, p, xv, yv, av, ea, od, cr, nb, rd);
    t = tagFor(m);
    sx = scramble ? " R13" : "";
    opt = (m inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd11, 4'd12}) ? "R11" : t;
    @(negedge clk);
    wait_n = 0;
    while (!reqReady && wait_n < 50) begin @(negedge clk); wait_n++; end
    mode = m; pc = p; xIdx = xv; yIdx = yv; accIn = av; reqValid = 1'b1;
    @(posedge clk);
    #1;
    if (scramble) begin
      mode = ~m; pc = ~p; xIdx = ~xv; yIdx = yv + 8'd77; accIn = ~av;
    end else begin
      reqValid = 1'b0;
    end
    seen = 0; wait_n = 0;
    forever begin
      @(negedge clk);
      if (memRd) seen++;
      if (done) break;
      wait_n++;
      if (wait_n > 40) begin
        chk(1'b0, {"R1 done timeout", sx}, 0, 1);
        reqValid = 1'b0;
        return;
      end
    end
    reqValid = 1'b0;
    chk(effAddr == ea,   {t, " effAddr", sx}, effAddr, ea);
    chk(operand == od,   {opt, " operand", sx}, operand, od);
    chk(pageCross == cr, {((m inside {4'd3, 4'd8, 4'd9, 4'd12}) ? t : "R12"), " pageCross", sx},
        pageCross, cr);
    chk(byteCount == nb, {"R2 byteCount", sx}, byteCount, nb);
    chk(seen == rd,      {t, " read count", sx}, seen, rd);
    @(negedge clk);
    chk(!done,           "R1 done pulse", done, 0);
    chk(effAddr == ea && operand == od && pageCross == cr, "R1 hold", effAddr, ea);
    chk(reqReady,        "R1 ready after done", reqReady, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady,        "R1 reset ready", reqReady, 1);
    chk(!done,           "R1 reset done", done, 0);
    chk(!memRd,          "R1 reset memRd", memRd, 0);
    chk(effAddr == 16'h0, "R1 reset effAddr", effAddr, 0);

    // Directed corners
    salt = 8'h3C;
    runReq(4'd0, 16'h1234, 8'h01, 8'h02, 8'hA5, 1'b0);   // R9 accumulator
    runReq(4'd1, 16'h1234, 8'h01, 8'h02, 8'hA5, 1'b0);   // R9 implied
    runReq(4'd2, 16'h8000, 8'h00, 8'h00, 8'h00, 1'b0);   // R10 immediate
    salt = saltFor(16'h80FE, 8'h05);
    runReq(4'd3, 16'h80FE, 8'h00, 8'h00, 8'h00, 1'b0);   // R10 forward cross
    salt = saltFor(16'h8002, 8'hF0);
    runReq(4'd3, 16'h8002, 8'h00, 8'h00, 8'h00, 1'b0);   // R10 backward cross
    salt = saltFor(16'hC000, 8'hF0);
    runReq(4'd5, 16'hC000, 8'h20, 8'h00, 8'h00, 1'b0);   // R5 zp+X wrap
    salt = saltFor(16'hC001, 8'hF0);
    runReq(4'd8, 16'hC000, 8'h20, 8'h00, 8'h00, 1'b0);   // R4 X cross
    salt = saltFor(16'hC010, 8'hFF);
    runReq(4'd10, 16'hC010, 8'h00, 8'h00, 8'h00, 1'b0);  // R8 lo=FF
    salt = 8'h11;
    runReq(4'd11, 16'h9000, 8'hFF - memFn(16'h9000), 8'h00, 8'h00, 1'b0); // R6 at FF
    salt = saltFor(16'h9100, 8'hFF);
    runReq(4'd12, 16'h9100, 8'h00, 8'hFF, 8'h00, 1'b0);  // R7 ptr at FF
    salt = 8'h6B;
    runReq(4'd7, 16'hFFFF, 8'h00, 8'h00, 8'h00, 1'b0);   // R3 pc+1 wraps
    runReq(4'd12, 16'h4567, 8'h3A, 8'hC4, 8'h99, 1'b1);  // R13 scrambled

    // Constrained random
    for (int i = 0; i < 600; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 12));
      salt = 8'($urandom);
      runReq(m, 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             ($urandom_range(0, 3) == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule